// File: doc/BRIEF.md
# Bus-Idle Sleep Controller

This block decides when a battery gauge core stops working and when it starts again. It has two ways to enter the halted state. The first is a bus-idle timeout: both serial bus lines stay low for a programmable number of clock ticks (2.5 s of system clock by default). The second is a software sleep bit taken from the configuration register. The block raises a `halt` output that freezes the gauge pipeline. It also reports which path caused the sleep, so the rest of the chip can tell the two kinds of sleep apart.

Each entry path has its own exit rule. A sleep caused by idle lines ends on the first rising edge of either bus line. A sleep caused by the sleep bit ignores all line activity. It ends only when the bit returns to 0 or when reset is applied. The block does not clear any gauge state. The pipeline only stalls, so the gauge resumes where it stopped. The bus line inputs must already be synchronised to `clk`.

Top module: `bus_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block is awake after that edge: `halt` = 0 and `sleep_src` = 2'b00.
- R2: When both `sda_in` and `scl_in` are sampled low for IDLE_TICKS consecutive rising edges while awake, with `cfg_sleep` low, the block enters line sleep after the last of those edges: `sleep_src` = 2'b01 and `halt` = 1. After IDLE_TICKS-1 such edges it is still awake.
- R3: A single edge at which either line is sampled high restarts the idle count from zero.
- R4: In line sleep, an edge at which SDA or SCL is sampled high after being sampled low (a rising edge) returns the block to awake after that same clock edge. SDA and SCL each work on their own.
- R5: When `cfg_sleep` is sampled 1, the block is in bit sleep (`sleep_src` = 2'b10, `halt` = 1) after that edge. This applies from awake and from line sleep.
- R6: In bit sleep, line edges and long line-low periods have no effect, and the block stays in bit sleep.
- R7: Bit sleep ends after the first edge at which `cfg_sleep` is sampled 0, or through reset.
- R8: Line-low time spent in bit sleep does not count. After bit sleep ends, the block needs a full IDLE_TICKS further low edges before it enters line sleep.
- R9: `halt` is 1 exactly when `sleep_src` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sda_in | input | 1 | Synchronised data line level |
| scl_in | input | 1 | Synchronised clock line level |
| cfg_sleep | input | 1 | Software sleep bit from the configuration register |
| halt | output | 1 | Freezes the gauge pipeline while high |
| sleep_src | output | 2 | 00 awake, 01 line sleep, 10 bit sleep |

## Verification
Every result appears after one clock edge. A change of `cfg_sleep` and a line rising edge both show on the outputs after the next rising edge. Line-sleep entry shows after exactly IDLE_TICKS edges with both lines low. The bench drives inputs on falling edges, counts rising edges, and samples on the following falling edge. For the timeout it checks both IDLE_TICKS-1 edges (still awake) and IDLE_TICKS edges (asleep), so a count that is off by one edge either way is caught.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_LINE = 2'b01,
    SRC_BIT  = 2'b10
  } sleep_src_e;
endpackage

// File: rtl/line_edge_mon.sv
module line_edge_mon #(
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  output logic                 all_low,
  output logic                 any_rise
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rise;

  // idle bus level is high, so reset previous level high to avoid a false edge
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b1;
      else     prev_q[i] <= lines[i];
    end
    assign rise[i] = lines[i] & ~prev_q[i];
  end

  assign all_low  = ~|lines;
  assign any_rise = |rise;

  // R4
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    any_rise |-> (prev_q != {NUM_LINES{1'b1}}));
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int IDLE_TICKS = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (IDLE_TICKS > 2) ? $clog2(IDLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sleep,
  input  logic       idle_expire,
  input  logic       line_rise,
  output sleep_src_e state,
  output logic       halt
);
  sleep_src_e state_q, state_d;
  logic       halt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_NONE: begin
        if (cfg_sleep)        state_d = SRC_BIT;
        else if (idle_expire) state_d = SRC_LINE;
      end
      SRC_LINE: begin
        if (cfg_sleep)      state_d = SRC_BIT;
        else if (line_rise) state_d = SRC_NONE;
      end
      SRC_BIT: begin
        if (!cfg_sleep) state_d = SRC_NONE;
      end
      default: state_d = SRC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_NONE;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= (state_d != SRC_NONE);
    end
  end

  assign state = state_q;
  assign halt  = halt_q;

  // R1
  reset_awake_chk: assert property (@(posedge clk)
    rst |=> (state_q == SRC_NONE && !halt_q));
  // R2
  line_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SRC_NONE && idle_expire && !cfg_sleep) |=> state_q == SRC_LINE);
  // R4
  line_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SRC_LINE && line_rise && !cfg_sleep) |=> state_q == SRC_NONE);
  // R5
  bit_entry_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_sleep |=> state_q == SRC_BIT);
  // R7
  bit_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SRC_BIT && !cfg_sleep) |=> state_q == SRC_NONE);
endmodule

// File: rtl/bus_sleep_ctrl.sv
module bus_sleep_ctrl
  import sleep_ctl_pkg::*;
#(
  parameter int IDLE_TICKS = 125_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       cfg_sleep,
  output logic       halt,
  output logic [1:0] sleep_src
);
  localparam int NUM_LINES = 2;

  logic       all_low, any_rise, idle_expire, awake;
  sleep_src_e state;

  line_edge_mon #(.NUM_LINES(NUM_LINES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .lines    ({scl_in, sda_in}),
    .all_low  (all_low),
    .any_rise (any_rise)
  );

  // count only while awake, so time spent asleep never contributes
  assign awake = (state == SRC_NONE);

  idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (awake && all_low),
    .expire (idle_expire)
  );

  sleep_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cfg_sleep   (cfg_sleep),
    .idle_expire (idle_expire),
    .line_rise   (any_rise),
    .state       (state),
    .halt        (halt)
  );

  assign sleep_src = state;

  // R9
  halt_match_chk: assert property (@(posedge clk) disable iff (rst)
    halt == (sleep_src != 2'b00));
  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_src == 2'b10 && cfg_sleep) |=> sleep_src == 2'b10);
endmodule

// File: tb/bus_sleep_ctrl_test.sv
module bus_sleep_ctrl_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_in = 1'b1;
  logic scl_in = 1'b1;
  logic cfg_sleep = 1'b0;
  logic halt;
  logic [1:0] sleep_src;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bus_sleep_ctrl #(.IDLE_TICKS(N)) uut (
    .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
    .cfg_sleep(cfg_sleep), .halt(halt), .sleep_src(sleep_src)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] exp_src);
    n_run++;
    if (sleep_src !== exp_src || halt !== (exp_src != 2'b00)) begin
      n_fail++;
      $display("FAIL %s: src=%b halt=%b expected src=%b halt=%b",
               tag, sleep_src, halt, exp_src, exp_src != 2'b00);
    end
  endtask

  task automatic go_awake();
    @(negedge clk);
    sda_in = 1'b1; scl_in = 1'b1; cfg_sleep = 1'b0; rst = 1'b1;
    step(1);
    rst = 1'b0;
  endtask

  task automatic enter_line();
    sda_in = 1'b0; scl_in = 1'b0;
    step(N);
  endtask

  task automatic t_reset();
    step(2);
    rst = 1'b0;
    check("R1 reset state", 2'b00);
  endtask

  task automatic t_line_entry();
    go_awake();
    sda_in = 1'b0; scl_in = 1'b0;
    step(N - 1);
    check("R2 awake after N-1 low edges", 2'b00);
    step(1);
    check("R2 line sleep after N low edges", 2'b01);
    check("R9 halt while line sleep", 2'b01);
  endtask

  task automatic t_restart();
    go_awake();
    sda_in = 1'b0; scl_in = 1'b0;
    step(N - 1);
    scl_in = 1'b1;
    step(1);
    scl_in = 1'b0;
    step(N - 1);
    check("R3 count restarted by high line", 2'b00);
    step(1);
    check("R3 full count after restart", 2'b01);
  endtask

  task automatic t_line_exit(input bit use_scl);
    go_awake();
    enter_line();
    check("R4 in line sleep", 2'b01);
    step(3);
    check("R4 line sleep held while lines low", 2'b01);
    if (use_scl) scl_in = 1'b1; else sda_in = 1'b1;
    step(1);
    check(use_scl ? "R4 SCL rise exits" : "R4 SDA rise exits", 2'b00);
  endtask

  task automatic t_bit_entry();
    go_awake();
    cfg_sleep = 1'b1;
    step(1);
    check("R5 bit sleep from awake", 2'b10);
    check("R9 halt while bit sleep", 2'b10);
  endtask

  task automatic t_bit_ignores();
    go_awake();
    cfg_sleep = 1'b1;
    step(1);
    for (int i = 0; i < 4; i++) begin
      sda_in = 1'b0; scl_in = 1'b0;
      step(1);
      sda_in = i[0]; scl_in = ~i[0];
      step(1);
      check("R6 edges ignored in bit sleep", 2'b10);
    end
    sda_in = 1'b0; scl_in = 1'b0;
    step(3 * N);
    check("R6 long low ignored in bit sleep", 2'b10);
    cfg_sleep = 1'b0;
    step(1);
    check("R7 bit cleared exits", 2'b00);
  endtask

  task automatic t_bit_from_line();
    go_awake();
    enter_line();
    cfg_sleep = 1'b1;
    step(1);
    check("R5 bit sleep from line sleep", 2'b10);
    sda_in = 1'b1;
    step(1);
    check("R6 rise ignored after bit over line", 2'b10);
  endtask

  task automatic t_fresh_count();
    go_awake();
    cfg_sleep = 1'b1;
    sda_in = 1'b0; scl_in = 1'b0;
    step(2 * N);
    cfg_sleep = 1'b0;
    step(1);
    check("R7 exit with lines low", 2'b00);
    step(N - 1);
    check("R8 no credit for asleep time", 2'b00);
    step(1);
    check("R8 full count after bit exit", 2'b01);
  endtask

  task automatic t_reset_exit();
    go_awake();
    cfg_sleep = 1'b1;
    step(2);
    check("R5 bit sleep before reset", 2'b10);
    rst = 1'b1; cfg_sleep = 1'b0;
    step(1);
    rst = 1'b0;
    check("R7 reset ends bit sleep", 2'b00);
    check("R1 reset awake", 2'b00);
  endtask

  initial begin
    step(1);
    fork
      begin
        t_reset();
        t_line_entry();
        t_restart();
        t_line_exit(1'b0);
        t_line_exit(1'b1);
        t_bit_entry();
        t_bit_ignores();
        t_bit_from_line();
        t_fresh_count();
        t_reset_exit();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule